// File: doc/BRIEF.md
# Grouped-Backoff Anti-Collision Round Sequencer

This block is the reader-side sequencer for one anti-collision round in a population of tags. Each tag backs off by a group number and a step count. A start pulse opens the round. The block then issues an initialise command. After a fixed settling interval it grants permission to reply.

From then on, each reply slot ends with a verdict from the receive path:
- nothing heard,
- one clean reply, or
- a reply that failed its integrity check.

The sequencer answers every verdict with the matching confirm command. It counts step-decrements within the current group. Once enough of them have gone by, it moves the population on by one group. After the last group advance it closes the round with a stop command.

Two kinds of round exist. A base round always walks through fifteen groups. An improved round walks 2^m groups for m group bits, plus one extra group for tags whose step count overflowed into a fresh last group. The block also tallies the empty slots of the round. Software can read this tally to choose a narrower group field for the next round.

Top module: `grp_arb_seq`

## Requirements
- R1: While reset is held and right after it, cmd_valid, id_read and done are 0 and empty_cnt is 0.
- R2: A start pulse while no round runs produces an initialise command (cmd_op 0, cmd_arg 0) one cycle later, clears done and clears empty_cnt. A start pulse during a round has no effect.
- R3: The allow-reply command (cmd_op 1, cmd_arg 0) follows the initialise command by exactly SETTLE cycles.
- R4: A clean-reply verdict in a reply slot produces, one cycle later, a confirm command (cmd_op 2) with the step-decrement argument (cmd_arg 0). An id_read pulse comes in the same cycle.
- R5: A failed-check verdict produces, one cycle later, a confirm with the increment argument (cmd_arg 1). This verdict wins over any other verdict raised in the same cycle. It also zeroes the count of step-decrements in the group.
- R6: A no-reply verdict produces, one cycle later, a confirm with the step-decrement argument and adds 1 to empty_cnt.
- R7: After L step-decrement confirms with no group advance and no failed check between them, the very next cycle carries a confirm with the group-advance argument (cmd_arg 2). L comes from low_limit, and a value of 0 acts as 1.
- R8: In a base round (improved 0), the cycle after the 15th group advance carries the stop command (cmd_op 3). done rises in that same cycle and holds until the next start.
- R9: In an improved round, the number of group advances is 2^m + 1, where m is grp_bits limited to the range 1 to 4.
- R10: Mode, group bits and L are captured at start. Changes to them during a round do not affect that round.
- R11: Verdicts arriving outside a reply slot are ignored. This covers the settling interval, the cycle of a group advance and the idle state. Such verdicts give no command and no empty_cnt change.
- R12: cmd_valid is a single-cycle strobe. At most one command is issued per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a round when idle |
| improved | input | 1 | 1 selects the improved round length |
| grp_bits | input | 3 | Group field width m for improved rounds |
| low_limit | input | 4 | Step-decrements per group, L |
| slot_empty | input | 1 | Verdict: no reply within the slot |
| slot_good | input | 1 | Verdict: one reply, integrity check passed |
| slot_bad | input | 1 | Verdict: reply failed CRC or length check |
| cmd_valid | output | 1 | Command strobe |
| cmd_op | output | 2 | 0 initialise, 1 allow-reply, 2 confirm, 3 stop |
| cmd_arg | output | 2 | Confirm argument: 0 step-decrement, 1 increment, 2 group advance |
| id_read | output | 1 | Pulse: a tag identity was captured |
| done | output | 1 | Round complete |
| empty_cnt | output | ECW | Empty slots in the current or last round |

## Verification
The group advance is the hardest event to reach. It needs L step-decrement verdicts in a row with no failed check among them, and the count has to survive verdicts that arrive in the advance cycle itself, where they are dropped. The stimulus cycles a verdict pattern through a stride that is coprime with its period. This guarantees runs of clean and empty verdicts longer than L, with collisions and double-flag cycles mixed in. The bench runs base and improved rounds with clamped and unclamped group widths and limits, so every round-length formula is driven to its stop command.

// File: rtl/grp_arb_seq.sv
module grp_arb_seq #(
  parameter int SETTLE = 8,
  parameter int ECW    = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           improved,
  input  logic [2:0]     grp_bits,
  input  logic [3:0]     low_limit,
  input  logic           slot_empty,
  input  logic           slot_good,
  input  logic           slot_bad,
  output logic           cmd_valid,
  output logic [1:0]     cmd_op,
  output logic [1:0]     cmd_arg,
  output logic           id_read,
  output logic           done,
  output logic [ECW-1:0] empty_cnt
);
  localparam int SCW = $clog2(SETTLE) + 1;

  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_WAIT, S_HDEC, S_STOP} st_t;
  st_t st;

  logic [SCW-1:0] scnt;
  logic [3:0]     lcnt, llim;
  logic [4:0]     hcnt, hlim;
  logic [2:0]     m_eff;
  logic           in_wait;

  assign in_wait = (st == S_WAIT);
  assign m_eff = (grp_bits == 3'd0) ? 3'd1 : (grp_bits > 3'd4) ? 3'd4 : grp_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      scnt      <= '0;
      lcnt      <= '0;
      hcnt      <= '0;
      llim      <= 4'd1;
      hlim      <= 5'd15;
      cmd_valid <= 1'b0;
      cmd_op    <= 2'd0;
      cmd_arg   <= 2'd0;
      id_read   <= 1'b0;
      done      <= 1'b0;
      empty_cnt <= '0;
    end else begin
      cmd_valid <= 1'b0;
      id_read   <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          cmd_valid <= 1'b1;
          cmd_op    <= 2'd0;
          cmd_arg   <= 2'd0;
          done      <= 1'b0;
          empty_cnt <= '0;
          scnt      <= '0;
          lcnt      <= '0;
          hcnt      <= '0;
          llim      <= (low_limit == 4'd0) ? 4'd1 : low_limit;
          hlim      <= improved ? 5'((5'd1 << m_eff) + 5'd1) : 5'd15;
          st        <= S_SETTLE;
        end
        S_SETTLE: begin
          if (scnt == SCW'(SETTLE - 1)) begin
            cmd_valid <= 1'b1;
            cmd_op    <= 2'd1;
            cmd_arg   <= 2'd0;
            st        <= S_WAIT;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (slot_bad) begin
            cmd_valid <= 1'b1;
            cmd_op    <= 2'd2;
            cmd_arg   <= 2'd1;
            lcnt      <= '0;
          end else if (slot_good || slot_empty) begin
            cmd_valid <= 1'b1;
            cmd_op    <= 2'd2;
            cmd_arg   <= 2'd0;
            id_read   <= slot_good;
            if (!slot_good) empty_cnt <= empty_cnt + 1'b1;
            lcnt <= lcnt + 1'b1;
            if (4'(lcnt + 4'd1) == llim) st <= S_HDEC;
          end
        end
        S_HDEC: begin
          cmd_valid <= 1'b1;
          cmd_op    <= 2'd2;
          cmd_arg   <= 2'd2;
          lcnt      <= '0;
          hcnt      <= hcnt + 1'b1;
          st        <= (5'(hcnt + 5'd1) == hlim) ? S_STOP : S_WAIT;
        end
        S_STOP: begin
          cmd_valid <= 1'b1;
          cmd_op    <= 2'd3;
          cmd_arg   <= 2'd0;
          done      <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module grp_arb_seq_chk #(
  parameter int ECW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           slot_bad,
  input logic           in_wait,
  input logic           cmd_valid,
  input logic [1:0]     cmd_op,
  input logic [1:0]     cmd_arg,
  input logic           id_read,
  input logic           done,
  input logic [ECW-1:0] empty_cnt
);
  assert_init_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0) |-> $past(start));

  assert_id_with_confirm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    id_read |-> (cmd_valid && cmd_op == 2'd2 && cmd_arg == 2'd0));

  assert_bad_gives_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && slot_bad) |=> (cmd_valid && cmd_op == 2'd2 && cmd_arg == 2'd1));

  assert_empty_steps_by_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(empty_cnt) |-> (empty_cnt == ECW'($past(empty_cnt) + 1'b1) || empty_cnt == '0));

  assert_stop_sets_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3) |-> done);

  assert_done_not_in_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_wait);

  assert_no_verdict_outside_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_wait && !start) |=> !(cmd_valid && cmd_op == 2'd2 && cmd_arg != 2'd2));
endmodule

bind grp_arb_seq grp_arb_seq_chk #(.ECW(ECW)) u_chk (.*);

// File: tb/grp_arb_seq_tb.sv
module grp_arb_seq_tb;
  localparam int SETTLE = 8;
  localparam int ECW    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, improved = 1'b0;
  logic [2:0] grp_bits = 3'd4;
  logic [3:0] low_limit = 4'd4;
  logic slot_empty = 1'b0, slot_good = 1'b0, slot_bad = 1'b0;
  logic cmd_valid, id_read, done;
  logic [1:0] cmd_op, cmd_arg;
  logic [ECW-1:0] empty_cnt;

  always #2 clk = ~clk;

  grp_arb_seq #(.SETTLE(SETTLE), .ECW(ECW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .improved(improved),
    .grp_bits(grp_bits), .low_limit(low_limit), .slot_empty(slot_empty),
    .slot_good(slot_good), .slot_bad(slot_bad), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_arg(cmd_arg), .id_read(id_read), .done(done),
    .empty_cnt(empty_cnt));

  int compared = 0, mismatched = 0, cycles = 0;
  string phase = "R1 reset";

  // behavioural reference: phase 0 idle,1 settle,2 slot,3 advance,4 stop
  int mph = 0, msc = 0, mlow = 0, mhigh = 0, mllim = 1, mhlim = 15;
  bit e_v = 0, e_id = 0, e_done = 0;
  int e_op = 0, e_arg = 0, e_emp = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mph <= 0; e_v <= 0; e_id <= 0; e_done <= 0; e_emp <= 0;
    end else begin
      e_v <= 0; e_id <= 0;
      if (mph == 0) begin
        if (start) begin
          int m;
          m = (grp_bits == 0) ? 1 : (grp_bits > 4) ? 4 : int'(grp_bits);
          e_v <= 1; e_op <= 0; e_arg <= 0; e_done <= 0; e_emp <= 0;
          msc <= 0; mlow <= 0; mhigh <= 0;
          mllim <= (low_limit == 0) ? 1 : int'(low_limit);
          mhlim <= improved ? (2 ** m) + 1 : 15;
          mph <= 1;
        end
      end else if (mph == 1) begin
        if (msc == SETTLE - 1) begin
          e_v <= 1; e_op <= 1; e_arg <= 0; mph <= 2;
        end else msc <= msc + 1;
      end else if (mph == 2) begin
        if (slot_bad) begin
          e_v <= 1; e_op <= 2; e_arg <= 1; mlow <= 0;
        end else if (slot_good || slot_empty) begin
          e_v <= 1; e_op <= 2; e_arg <= 0; e_id <= slot_good;
          if (!slot_good) e_emp <= e_emp + 1;
          mlow <= mlow + 1;
          if (mlow + 1 == mllim) mph <= 3;
        end
      end else if (mph == 3) begin
        e_v <= 1; e_op <= 2; e_arg <= 2; mlow <= 0; mhigh <= mhigh + 1;
        mph <= (mhigh + 1 == mhlim) ? 4 : 2;
      end else begin
        e_v <= 1; e_op <= 3; e_arg <= 0; e_done <= 1; mph <= 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit bad;
      compared++;
      bad = (cmd_valid !== e_v) || (id_read !== e_id) || (done !== e_done) ||
            (int'(empty_cnt) != e_emp) ||
            (e_v && (int'(cmd_op) != e_op || int'(cmd_arg) != e_arg));
      if (bad) begin
        mismatched++;
        $display("FAIL %s @%0t: got v=%0b op=%0d arg=%0d id=%0b done=%0b emp=%0d exp v=%0b op=%0d arg=%0d id=%0b done=%0b emp=%0d",
          phase, $time, cmd_valid, cmd_op, cmd_arg, id_read, done, empty_cnt,
          e_v, e_op, e_arg, e_id, e_done, e_emp);
      end
    end
  end

  task automatic step(input bit s, input bit b, input bit g, input bit e);
    @(posedge clk); #1;
    start = s; slot_bad = b; slot_good = g; slot_empty = e;
  endtask

  // verdict pattern: stride 5 over period 16 gives long clean runs
  task automatic run_round(input bit imp, input int m, input int l, input int seed, input string tag);
    phase = tag;
    improved = imp; grp_bits = 3'(m); low_limit = 4'(l);
    step(1, 0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = (i * 5 + seed) % 16;
      if (i == 3) begin
        phase = {tag, " / R2 start ignored mid-round"};
        step(1, 0, 1, 0);
      end else begin
        if (i == 1) phase = {tag, " / R3 R11 settle"};
        if (i == 12) phase = {tag, " / R4 R5 R6 R7 slots"};
        if (i == 6) begin
          improved = ~imp; grp_bits = 3'd1; low_limit = 4'd9; // R10 changes ignored
        end
        step(0, k == 9 || k == 10, k <= 4 || k == 10, k >= 5 && k <= 8);
      end
      if (i > 12 && e_done && mph == 0) break;
    end
    step(0, 0, 0, 0);
    phase = {tag, " / R11 idle verdicts"};
    step(0, 1, 1, 1);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog R12: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    compared++;
    if (cmd_valid !== 1'b0 || done !== 1'b0 || id_read !== 1'b0 || empty_cnt !== '0) begin
      mismatched++;
      $display("FAIL R1 reset: got v=%0b done=%0b id=%0b emp=%0d expected 0 0 0 0",
        cmd_valid, done, id_read, empty_cnt);
    end
    run_round(0, 4, 4, 0, "R8 base round");
    run_round(1, 2, 2, 3, "R9 improved m=2");
    run_round(1, 0, 0, 7, "R9 R7 improved clamp m=0 L=0");
    run_round(1, 7, 3, 11, "R9 improved clamp m=7");
    run_round(0, 1, 1, 5, "R12 base round L=1");
    compared++;
    if (done !== 1'b1) begin
      mismatched++;
      $display("FAIL R8 final done: got %0b expected 1", done);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule